// File: doc/BRIEF.md
# Telescope Safety Fault Interlock Controller

This block collects the stop-switch, limit-switch and comparator fault signals of a telescope mount, qualifies each one on a slow sampling tick and drives the interlock outputs. A fault counts only if it is seen on two consecutive slow ticks. A shorter glitch is filtered out. Once a fault is confirmed, its status bit stays set until the active-low reset. While any status bit is set, every control output is held at its safe value.

The slow tick is a single-cycle enable derived from the system clock (nominally 7.5 Hz). All external inputs are asynchronous and pass through two-flop synchronizers. A limit-override switch can mask the axis travel limits, the horizon stop and the first spare input. It cannot mask the comparator faults, the main emergency stop or the hand-paddle stop.

The four control outputs use mixed polarities. When no fault is present:

- The dome amplifier enable is active low.
- The telescope inhibit is high when the amplifier is off and the brakes are applied.
- The TCS lamp is lit.
- The brake lamp follows the telescope inhibit.

Top module: `safety_interlock`

## Requirements
- R1: While `rst_n` is 0, the outputs take their safe values: `dome_en_n`=1, `tel_inhibit`=1, `lamp_tcs`=0 and `lamp_brake`=1. All `fault_flags` bits are 0.
- R2: With no fault flag set, `dome_en_n` is 0 when `dome_sw_req` or `dome_hp_req` is 1, and is 1 otherwise.
- R3: With no fault flag set, `lamp_tcs` is 1. `tel_inhibit` and `lamp_brake` are both 1 when `tel_sw_req` or `brake_en_req` is 0, and both are 0 when the two requests are 1.
- R4: A fault present at only one slow tick, or at non-consecutive ticks, sets no flag.
- R5: A fault present at two consecutive slow ticks sets its flag on the second tick. The flag then stays set after the input clears, until reset.
- R6: While any fault flag is 1, all four control outputs hold their safe values. This starts from the cycle in which the flag appears.
- R7: When `lim_override` is 1, the limit inputs (flag bits 0 to N_LIM-1) are treated as absent at each tick. Comparator faults (bits N_LIM to N_LIM+N_CMP-1) are still qualified.
- R8: `estop_ok`=0 is a fault that cannot be masked. Its flag is bit N_LIM+N_CMP, which is bit 19 with the default parameters.
- R9: `hp_open`=1 is a fault that cannot be masked. Its flag is bit N_LIM+N_CMP+1, which is bit 20 with the default parameters.
- R10: Without slow ticks, a fault held for any number of cycles sets no flag.
- R11: Fault flags change only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle slow sampling enable |
| lim_open | input | N_LIM | Limit/stop switches and spare, 1 = open = stop |
| cmp_trip | input | N_CMP | Overspeed/overcurrent comparator trips, 1 = fault |
| estop_ok | input | 1 | Main emergency stop, 1 = no stop |
| hp_open | input | 1 | Hand-paddle stop, 1 = stop |
| lim_override | input | 1 | Masks the limit inputs while 1 |
| dome_sw_req | input | 1 | Dome under software control request |
| dome_hp_req | input | 1 | Dome under hand-paddle control request |
| tel_sw_req | input | 1 | Telescope enable switch, 0 = disable |
| brake_en_req | input | 1 | Brake release request, 0 = brake |
| dome_en_n | output | 1 | Dome amplifier enable, active low |
| tel_inhibit | output | 1 | 1 = telescope amplifier off and brakes on |
| lamp_tcs | output | 1 | Panel TCS lamp, 1 = lit |
| lamp_brake | output | 1 | Panel brake lamp, 1 = lit |
| fault_flags | output | N_LIM+N_CMP+2 | Latched per-fault status, 1 = fault |

## Verification
Two events can fall in the same cycle: a fault is confirmed on a tick, and an operator request changes. The bench provokes this by driving the tick and dropping the dome request on the same negedge, with a limit fault already seen at the previous tick. It then judges that the outputs are safe on the very next sample. A second collision comes from toggling the override between two ticks. The masked sample must break the consecutive-tick chain, so the flag appears only after two fresh unmasked ticks.

// File: rtl/safety_pkg.sv
package safety_pkg;

    localparam int EXTRA_FAULTS = 2;   // emergency stop and hand-paddle stop

    typedef struct packed {
        logic dome_en_n;
        logic tel_inhibit;
        logic lamp_tcs;
        logic lamp_brake;
    } ctl_out_t;

    localparam ctl_out_t SAFE_OUT = '{dome_en_n: 1'b1, tel_inhibit: 1'b1,
                                      lamp_tcs: 1'b0, lamp_brake: 1'b1};

    typedef struct packed {
        logic seen;   // fault present at previous tick
        logic flag;   // confirmed, sticky
    } qual_bit_t;

endpackage

// File: rtl/si_sync.sv
module si_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/si_qualify.sv
module si_qualify
    import safety_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] raw,
    output logic [N-1:0] flag_d,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        qual_bit_t b_d, b_q;

        always_comb begin
            b_d = b_q;
            if (tick) begin
                b_d.seen = raw[i];
                b_d.flag = b_q.flag | (raw[i] & b_q.seen);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                b_q <= '{seen: 1'b0, flag: 1'b0};
            end else begin
                b_q <= b_d;
            end
        end

        assign flag_d[i] = b_d.flag;
        assign flag_q[i] = b_q.flag;
    end
endmodule

// File: rtl/si_outputs.sv
module si_outputs
    import safety_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fault_next,
    input  logic     dome_sw,
    input  logic     dome_hp,
    input  logic     tel_sw,
    input  logic     brake_en,
    output ctl_out_t out_q
);
    ctl_out_t out_d;
    logic     inhibit;

    always_comb begin
        inhibit = ~(tel_sw & brake_en);
        if (fault_next) begin
            out_d = SAFE_OUT;
        end else begin
            out_d.dome_en_n   = ~(dome_sw | dome_hp);
            out_d.tel_inhibit = inhibit;
            out_d.lamp_tcs    = 1'b1;
            out_d.lamp_brake  = inhibit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= SAFE_OUT;
        end else begin
            out_q <= out_d;
        end
    end
endmodule

// File: rtl/safety_interlock.sv
module safety_interlock
    import safety_pkg::*;
#(
    parameter int N_LIM = 10,
    parameter int N_CMP = 9
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick,
    input  logic [N_LIM-1:0]                lim_open,
    input  logic [N_CMP-1:0]                cmp_trip,
    input  logic                            estop_ok,
    input  logic                            hp_open,
    input  logic                            lim_override,
    input  logic                            dome_sw_req,
    input  logic                            dome_hp_req,
    input  logic                            tel_sw_req,
    input  logic                            brake_en_req,
    output logic                            dome_en_n,
    output logic                            tel_inhibit,
    output logic                            lamp_tcs,
    output logic                            lamp_brake,
    output logic [N_LIM+N_CMP+EXTRA_FAULTS-1:0] fault_flags
);
    localparam int N_FAULT = N_LIM + N_CMP + EXTRA_FAULTS;
    localparam int N_MISC  = 7;
    // misc order: brake_en, tel_sw, dome_hp, dome_sw, override, hp_open, estop_ok
    localparam logic [N_MISC-1:0] MISC_RST = 7'b000_0001;

    logic [N_LIM-1:0]   lim_s;
    logic [N_CMP-1:0]   cmp_s;
    logic [N_MISC-1:0]  misc_s;
    logic [N_FAULT-1:0] raw;
    logic [N_FAULT-1:0] flag_d;
    logic [N_FAULT-1:0] flag_q;
    ctl_out_t           ctl;

    si_sync #(.W(N_LIM), .RST_VAL('0)) u_sync_lim (
        .clk(clk), .rst_n(rst_n), .d(lim_open), .q(lim_s));

    si_sync #(.W(N_CMP), .RST_VAL('0)) u_sync_cmp (
        .clk(clk), .rst_n(rst_n), .d(cmp_trip), .q(cmp_s));

    si_sync #(.W(N_MISC), .RST_VAL(MISC_RST)) u_sync_misc (
        .clk(clk), .rst_n(rst_n),
        .d({brake_en_req, tel_sw_req, dome_hp_req, dome_sw_req,
            lim_override, hp_open, estop_ok}),
        .q(misc_s));

    // Fault vector: limits (maskable), comparators, e-stop (inverted), hand paddle
    for (genvar i = 0; i < N_LIM; i++) begin : g_mask
        assign raw[i] = lim_s[i] & ~misc_s[2];
    end
    assign raw[N_LIM +: N_CMP]   = cmp_s;
    assign raw[N_LIM + N_CMP]     = ~misc_s[0];
    assign raw[N_LIM + N_CMP + 1] = misc_s[1];

    si_qualify #(.N(N_FAULT)) u_qual (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(raw),
        .flag_d(flag_d), .flag_q(flag_q));

    si_outputs u_out (
        .clk(clk), .rst_n(rst_n), .fault_next(|flag_d),
        .dome_sw(misc_s[3]), .dome_hp(misc_s[4]),
        .tel_sw(misc_s[5]), .brake_en(misc_s[6]),
        .out_q(ctl));

    assign dome_en_n   = ctl.dome_en_n;
    assign tel_inhibit = ctl.tel_inhibit;
    assign lamp_tcs    = ctl.lamp_tcs;
    assign lamp_brake  = ctl.lamp_brake;
    assign fault_flags = flag_q;
endmodule

// File: rtl/safety_interlock_chk.sv
module safety_interlock_chk #(
    parameter int N_FAULT = 21
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic [N_FAULT-1:0] fault_flags,
    input logic               dome_en_n,
    input logic               tel_inhibit,
    input logic               lamp_tcs,
    input logic               lamp_brake
);
    p_reset_safe_r1: assert property (@(posedge clk)
        !rst_n |-> (dome_en_n && tel_inhibit && !lamp_tcs && lamp_brake && fault_flags == '0));

    p_brake_lamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_brake == tel_inhibit);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flags != '0) |=> ((fault_flags & $past(fault_flags)) == $past(fault_flags)));

    p_fault_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flags != '0) |-> (dome_en_n && tel_inhibit && !lamp_tcs && lamp_brake));

    p_tick_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(fault_flags));
endmodule

bind safety_interlock safety_interlock_chk #(.N_FAULT(N_LIM + N_CMP + 2)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fault_flags(fault_flags),
    .dome_en_n(dome_en_n), .tel_inhibit(tel_inhibit),
    .lamp_tcs(lamp_tcs), .lamp_brake(lamp_brake));

// File: tb/safety_interlock_test.sv
module safety_interlock_test;
    localparam int NL = 10;
    localparam int NC = 9;
    localparam int NF = NL + NC + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic tick = 1'b0;
    logic [NL-1:0] lim_open = '0;
    logic [NC-1:0] cmp_trip = '0;
    logic estop_ok = 1'b1, hp_open = 1'b0, lim_override = 1'b0;
    logic dome_sw_req = 1'b0, dome_hp_req = 1'b0, tel_sw_req = 1'b0, brake_en_req = 1'b0;
    logic dome_en_n, tel_inhibit, lamp_tcs, lamp_brake;
    logic [NF-1:0] fault_flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    safety_interlock #(.N_LIM(NL), .N_CMP(NC)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lim_open(lim_open), .cmp_trip(cmp_trip),
        .estop_ok(estop_ok), .hp_open(hp_open), .lim_override(lim_override),
        .dome_sw_req(dome_sw_req), .dome_hp_req(dome_hp_req),
        .tel_sw_req(tel_sw_req), .brake_en_req(brake_en_req),
        .dome_en_n(dome_en_n), .tel_inhibit(tel_inhibit),
        .lamp_tcs(lamp_tcs), .lamp_brake(lamp_brake), .fault_flags(fault_flags));

    // {override, dome_sw, dome_hp, tel_sw, brake_en, exp dome_en_n, tel_inhibit, lamp_tcs, lamp_brake}
    localparam logic [8:0] VEC [8] = '{
        9'b0_0000_1111, 9'b0_1011_0010, 9'b0_0110_0111, 9'b0_0001_1111,
        9'b1_1111_0010, 9'b0_1001_0111, 9'b1_0010_1111, 9'b0_0111_0010 };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] outs();
        return {28'd0, dome_en_n, tel_inhibit, lamp_tcs, lamp_brake};
    endfunction

    function automatic logic [31:0] bit_of(input int n);
        return 32'd1 << n;
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_faults();
        lim_open = '0; cmp_trip = '0; estop_ok = 1'b1; hp_open = 1'b0; lim_override = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 outputs in reset", outs(), 32'hD);
        chk("R1 flags in reset", 32'(fault_flags), 32'd0);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic enable_reqs();
        dome_sw_req = 1'b1; dome_hp_req = 1'b0; tel_sw_req = 1'b1; brake_en_req = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs safe", outs(), 32'hD);
        chk("R1 reset flags clear", 32'(fault_flags), 32'd0);
        rst_n = 1'b1;
        settle();

        // R2 R3: request table, no faults
        for (int i = 0; i < 8; i++) begin
            {lim_override, dome_sw_req, dome_hp_req, tel_sw_req, brake_en_req} = VEC[i][8:4];
            settle();
            chk($sformatf("R2 R3 vector %0d outputs", i), outs(), 32'(VEC[i][3:0]));
            chk($sformatf("R7 vector %0d flags", i), 32'(fault_flags), 32'd0);
        end
        lim_override = 1'b0;
        enable_reqs();
        settle();

        // R4: glitch seen at one tick only, then gap
        lim_open[3] = 1'b1; settle(); pulse_tick();
        lim_open[3] = 1'b0; settle(); pulse_tick(); pulse_tick();
        chk("R4 single-tick glitch ignored", 32'(fault_flags), 32'd0);
        chk("R4 outputs stay normal", outs(), 32'h2);

        // R10: held fault, no ticks
        cmp_trip[2] = 1'b1;
        repeat (50) @(negedge clk);
        chk("R10 no tick no flag", 32'(fault_flags), 32'd0);
        pulse_tick();
        chk("R4 first tick only", 32'(fault_flags), 32'd0);
        pulse_tick();
        chk("R5 comparator flag set", 32'(fault_flags), bit_of(NL + 2));
        chk("R6 outputs safe on fault", outs(), 32'hD);
        cmp_trip[2] = 1'b0; settle(); pulse_tick(); pulse_tick();
        chk("R5 flag sticky after clear", 32'(fault_flags), bit_of(NL + 2));
        chk("R6 outputs remain safe", outs(), 32'hD);
        do_reset();
        chk("R5 reset clears, outputs normal", outs(), 32'h2);

        // R7: override masks limits, not comparators
        lim_override = 1'b1; lim_open[9] = 1'b1; settle();
        pulse_tick(); pulse_tick(); pulse_tick();
        chk("R7 masked limit no flag", 32'(fault_flags), 32'd0);
        chk("R7 outputs normal under override", outs(), 32'h2);
        cmp_trip[0] = 1'b1; settle(); pulse_tick(); pulse_tick();
        chk("R7 comparator not maskable", 32'(fault_flags), bit_of(NL));
        clear_faults(); do_reset();

        // R7: override raised between ticks breaks the chain
        lim_open[0] = 1'b1; settle(); pulse_tick();
        lim_override = 1'b1; settle(); pulse_tick();
        lim_override = 1'b0; settle(); pulse_tick();
        chk("R7 masked tick breaks chain", 32'(fault_flags), 32'd0);
        pulse_tick();
        chk("R7 limit latched after two unmasked ticks", 32'(fault_flags), bit_of(0));
        clear_faults(); do_reset();

        // R8: emergency stop, inverted polarity
        lim_override = 1'b1; estop_ok = 1'b0; settle(); pulse_tick(); pulse_tick();
        chk("R8 estop flag", 32'(fault_flags), bit_of(NL + NC));
        chk("R8 outputs safe", outs(), 32'hD);
        clear_faults(); do_reset();

        // R9: hand paddle stop
        lim_override = 1'b1; hp_open = 1'b1; settle(); pulse_tick(); pulse_tick();
        chk("R9 hand paddle flag", 32'(fault_flags), bit_of(NL + NC + 1));
        clear_faults(); do_reset();

        // R6: confirming tick coincides with a request change
        chk("R2 enabled before collision", outs(), 32'h2);
        lim_open[5] = 1'b1; settle(); pulse_tick();
        @(negedge clk) begin tick = 1'b1; dome_sw_req = 1'b0; end
        @(negedge clk) tick = 1'b0;
        chk("R6 safe in confirm cycle", outs(), 32'hD);
        chk("R5 limit flag in confirm cycle", 32'(fault_flags), bit_of(5));
        settle();
        chk("R6 safe after request settles", outs(), 32'hD);
        clear_faults(); do_reset();

        finish_run();
    end
endmodule